// File: doc/BRIEF.md
# Speculative Store Buffers with Ordered Commit

This block keeps the speculative stores of several threads apart from the committed state held in a shared second-level line store. Every thread owns a small buffer of line-sized entries. Each entry carries a line tag, one valid flag per byte and the byte values. A store from a thread lands only in that thread's buffer. The shared store therefore holds nothing but committed data.

When a core misses in its first-level cache, it requests a line fill. The block reads the committed line and lays buffered bytes over it. Only two kinds of buffer are eligible: the requester's own buffer and the buffers of threads older than the requester. Buffers of younger threads are never consulted, so a thread never sees a store it would not yet have seen in sequential order.

The thread order is a ring that starts at the oldest thread. A thread asks to commit when it completes. The commit is taken only if that thread is currently the oldest. Its buffer is then written into the shared store, one line per cycle, with each line's byte flags acting as write enables. When the buffer is empty a done pulse is raised, and the next thread in the ring becomes the oldest. A thread that suffers a violation has its buffer discarded in one cycle.

Top module: `spec_store_buffers`

## Requirements
- R1: After reset, `st_stall`, `fill_valid` and `commit_done` are low, every buffer is empty and every byte of the shared store reads as zero. Thread 0 is the oldest.
- R2: An accepted byte store (`st_valid` high with `st_stall` low) records `st_byte` at offset `st_off` of line `st_line` in the buffer of thread `st_thr` only. A later store to a line already held by that thread uses the same entry and overwrites any byte it repeats.
- R3: `fill_valid` is high in exactly the cycle after each cycle in which `fill_req` is high. In that cycle `fill_data` holds the line, with byte k in bits 8k+7..8k. Each byte comes from an eligible buffer that holds it, and otherwise from the shared store.
- R4: The buffer of any thread younger than the requester has no effect on `fill_data`.
- R5: When several eligible buffers hold the same byte, the youngest of them supplies it: the requester's own buffer first, then the nearest older thread.
- R6: A thread's buffer holds 4 lines. A store to a fifth distinct line raises `st_stall` in the same cycle, and that store is dropped. A store to a line already held does not stall.
- R7: A commit request naming a thread that is not the oldest is ignored. No done pulse follows, and the buffer contents are kept.
- R8: An accepted commit of a buffer holding k lines writes one line per cycle and raises `commit_done` for one cycle, k+1 cycles after the accepting edge. Only the bytes flagged in each line change in the shared store, and the buffer is empty afterwards.
- R9: A bit set in `squash` discards the whole buffer of that thread at the next clock edge.
- R10: After each done pulse, the next thread number (modulo 4) becomes the oldest, and the committed thread becomes the youngest. Eligibility for fills follows this rotated order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Speculative byte store present |
| st_thr | input | 2 | Thread issuing the store |
| st_line | input | 6 | Line address of the store |
| st_off | input | 5 | Byte offset within the line |
| st_byte | input | 8 | Store data |
| st_stall | output | 1 | Store refused because the thread's buffer is full (or draining) |
| fill_req | input | 1 | Line fill request after a first-level miss |
| fill_thr | input | 2 | Requesting thread |
| fill_line | input | 6 | Line address requested |
| fill_valid | output | 1 | Fill result present |
| fill_data | output | 256 | Composite line, byte k in bits 8k+7..8k |
| commit_req | input | 1 | A completed thread asks to commit |
| commit_thr | input | 2 | Thread asking to commit |
| commit_done | output | 1 | One-cycle pulse: the committing buffer is empty |
| squash | input | 4 | Per-thread discard request |

## Verification
The hardest situation to reach is a fill whose answer depends on the rotated thread order. To reach it, the thread that was oldest must first commit, so that it becomes the youngest. The same line must also carry conflicting bytes in several buffers at that moment. The stimulus therefore loads one line with overlapping bytes from three threads and reads it from each thread. It then commits the oldest thread and reads the line again from the new youngest thread. This shows both the change in eligibility and the byte-level priority. The stimulus also fills one thread's buffer to its limit, before any commit, to reach the stall. Later it discards that buffer, so that its drain completes with an empty buffer.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    localparam int SSB_THREADS    = 4;
    localparam int SSB_ENTRIES    = 4;
    localparam int SSB_LINE_BYTES = 32;
    localparam int SSB_LINE_AW    = 6;
endpackage

// File: rtl/ssb_line_mem.sv
module ssb_line_mem #(
    parameter int LINE_BYTES = 32,
    parameter int LINE_AW    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [LINE_AW-1:0]      rd_line,
    output logic [LINE_BYTES*8-1:0] rd_data,
    input  logic                    wr_en,
    input  logic [LINE_AW-1:0]      wr_line,
    input  logic [LINE_BYTES-1:0]   wr_mask,
    input  logic [LINE_BYTES*8-1:0] wr_data
);
    localparam int LINES  = 1 << LINE_AW;
    localparam int LINE_W = LINE_BYTES * 8;

    logic [LINE_W-1:0] mem_q [LINES];
    logic [LINE_W-1:0] rd_q;

    // Committed state only; byte mask acts as write enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            if (rd_en) rd_q <= mem_q[rd_line];
            if (wr_en) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (wr_mask[b]) mem_q[wr_line][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/ssb_thread_buf.sv
module ssb_thread_buf #(
    parameter int ENTRIES    = 4,
    parameter int LINE_BYTES = 32,
    parameter int LINE_AW    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [LINE_AW-1:0]            wr_line,
    input  logic [$clog2(LINE_BYTES)-1:0] wr_off,
    input  logic [7:0]                    wr_byte,
    output logic                          wr_block,
    input  logic                          clr,
    input  logic                          pop,
    input  logic [LINE_AW-1:0]            look_line,
    output logic                          look_hit,
    output logic [LINE_BYTES-1:0]         look_mask,
    output logic [LINE_BYTES*8-1:0]       look_data,
    output logic [LINE_AW-1:0]            head_line,
    output logic [LINE_BYTES-1:0]         head_mask,
    output logic [LINE_BYTES*8-1:0]       head_data,
    output logic                          empty
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]                 vld;
        logic [ENTRIES-1:0][LINE_AW-1:0]    tag;
        logic [ENTRIES-1:0][LINE_BYTES-1:0] msk;
        logic [ENTRIES-1:0][LINE_W-1:0]     dat;
    } buf_t;

    buf_t s_d, s_q;
    logic             hit_w, free_w, head_w;
    logic [IDX_W-1:0] hit_idx, free_idx, head_idx, tgt;

    always_comb begin
        s_d       = s_q;
        hit_w     = 1'b0;
        free_w    = 1'b0;
        head_w    = 1'b0;
        hit_idx   = '0;
        free_idx  = '0;
        head_idx  = '0;
        tgt       = '0;
        look_hit  = 1'b0;
        look_mask = '0;
        look_data = '0;
        // Descending scan so the lowest matching index wins.
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (s_q.vld[i] && s_q.tag[i] == wr_line) begin
                hit_w   = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!s_q.vld[i]) begin
                free_w   = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (s_q.vld[i]) begin
                head_w   = 1'b1;
                head_idx = IDX_W'(i);
            end
            if (s_q.vld[i] && s_q.tag[i] == look_line) begin
                look_hit  = 1'b1;
                look_mask = s_q.msk[i];
                look_data = s_q.dat[i];
            end
        end
        if (pop && head_w) s_d.vld[head_idx] = 1'b0;
        if (wr_en && (hit_w || free_w)) begin
            tgt = hit_w ? hit_idx : free_idx;
            if (!hit_w) begin
                s_d.tag[tgt] = wr_line;
                s_d.msk[tgt] = '0;
            end
            s_d.vld[tgt]                          = 1'b1;
            s_d.msk[tgt][wr_off]                  = 1'b1;
            s_d.dat[tgt][{wr_off, 3'b000} +: 8]   = wr_byte;
        end
        if (clr) s_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_block  = !hit_w && !free_w;
    assign empty     = !head_w;
    assign head_line = s_q.tag[head_idx];
    assign head_mask = s_q.msk[head_idx];
    assign head_data = s_q.dat[head_idx];
endmodule

// File: rtl/spec_store_buffers.sv
module spec_store_buffers
    import ssb_pkg::*;
#(
    parameter int NUM_THR    = SSB_THREADS,
    parameter int ENTRIES    = SSB_ENTRIES,
    parameter int LINE_BYTES = SSB_LINE_BYTES,
    parameter int LINE_AW    = SSB_LINE_AW,
    localparam int THR_W     = $clog2(NUM_THR),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic [THR_W-1:0]   st_thr,
    input  logic [LINE_AW-1:0] st_line,
    input  logic [OFF_W-1:0]   st_off,
    input  logic [7:0]         st_byte,
    output logic               st_stall,
    input  logic               fill_req,
    input  logic [THR_W-1:0]   fill_thr,
    input  logic [LINE_AW-1:0] fill_line,
    output logic               fill_valid,
    output logic [LINE_W-1:0]  fill_data,
    input  logic               commit_req,
    input  logic [THR_W-1:0]   commit_thr,
    output logic               commit_done,
    input  logic [NUM_THR-1:0] squash
);
    typedef struct packed {
        logic [THR_W-1:0]      head;
        logic                  drain;
        logic                  done;
        logic                  fvld;
        logic [LINE_BYTES-1:0] omsk;
        logic [LINE_W-1:0]     odat;
    } top_t;

    top_t q, d;

    logic [NUM_THR-1:0]    b_block, b_hit, b_empty, b_wr, pop;
    logic [LINE_BYTES-1:0] b_lmask [NUM_THR];
    logic [LINE_W-1:0]     b_ldata [NUM_THR];
    logic [LINE_AW-1:0]    b_hline [NUM_THR];
    logic [LINE_BYTES-1:0] b_hmask [NUM_THR];
    logic [LINE_W-1:0]     b_hdata [NUM_THR];
    logic [LINE_W-1:0]     mem_rd;
    logic                  mem_we;
    logic [THR_W-1:0]      req_age, t_sel, head_thr;
    logic                  draining;

    assign st_stall = st_valid && (b_block[st_thr] || (q.drain && st_thr == q.head));

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        assign b_wr[t] = st_valid && !st_stall && (st_thr == THR_W'(t));
        ssb_thread_buf #(
            .ENTRIES   (ENTRIES),
            .LINE_BYTES(LINE_BYTES),
            .LINE_AW   (LINE_AW)
        ) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (b_wr[t]),
            .wr_line  (st_line),
            .wr_off   (st_off),
            .wr_byte  (st_byte),
            .wr_block (b_block[t]),
            .clr      (squash[t]),
            .pop      (pop[t]),
            .look_line(fill_line),
            .look_hit (b_hit[t]),
            .look_mask(b_lmask[t]),
            .look_data(b_ldata[t]),
            .head_line(b_hline[t]),
            .head_mask(b_hmask[t]),
            .head_data(b_hdata[t]),
            .empty    (b_empty[t])
        );
    end

    ssb_line_mem #(
        .LINE_BYTES(LINE_BYTES),
        .LINE_AW   (LINE_AW)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (fill_req),
        .rd_line(fill_line),
        .rd_data(mem_rd),
        .wr_en  (mem_we),
        .wr_line(b_hline[q.head]),
        .wr_mask(b_hmask[q.head]),
        .wr_data(b_hdata[q.head])
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fvld  = fill_req;
        mem_we  = 1'b0;
        pop     = '0;
        req_age = fill_thr - q.head;
        t_sel   = '0;
        // Ordered drain: only the oldest thread ever commits.
        if (q.drain) begin
            if (b_empty[q.head]) begin
                d.drain = 1'b0;
                d.done  = 1'b1;
                d.head  = q.head + 1'b1;
            end else begin
                pop[q.head] = 1'b1;
                mem_we      = 1'b1;
            end
        end else if (commit_req && commit_thr == q.head) begin
            d.drain = 1'b1;
        end
        // Overlay: walk from oldest to requester, younger eligible bytes override.
        if (fill_req) begin
            d.omsk = '0;
            d.odat = '0;
            for (int a = 0; a < NUM_THR; a++) begin
                t_sel = q.head + THR_W'(a);
                if (THR_W'(a) <= req_age && b_hit[t_sel]) begin
                    for (int b = 0; b < LINE_BYTES; b++) begin
                        if (b_lmask[t_sel][b]) begin
                            d.omsk[b]         = 1'b1;
                            d.odat[b*8 +: 8]  = b_ldata[t_sel][b*8 +: 8];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            fill_data[b*8 +: 8] = q.omsk[b] ? q.odat[b*8 +: 8] : mem_rd[b*8 +: 8];
        end
    end

    assign fill_valid  = q.fvld;
    assign commit_done = q.done;
    assign head_thr    = q.head;
    assign draining    = q.drain;
endmodule

// File: rtl/ssb_checks.sv
module ssb_checks #(
    parameter int THR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             st_stall,
    input logic             fill_req,
    input logic             fill_valid,
    input logic             commit_done,
    input logic             draining,
    input logic             mem_we,
    input logic [THR_W-1:0] head_thr
);
    a_r3_fill_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> fill_valid);
    a_r3_no_spurious_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> !fill_valid);
    a_r6_stall_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> st_valid);
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done);
    a_r8_write_only_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> draining);
    a_r10_head_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head_thr) |-> commit_done);
    a_r10_head_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> head_thr == THR_W'($past(head_thr) + 1'b1));
endmodule

bind spec_store_buffers ssb_checks #(.THR_W(THR_W)) u_ssb_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_stall   (st_stall),
    .fill_req   (fill_req),
    .fill_valid (fill_valid),
    .commit_done(commit_done),
    .draining   (draining),
    .mem_we     (mem_we),
    .head_thr   (head_thr)
);

// File: tb/spec_store_buffers_bench.sv
module spec_store_buffers_bench;
    localparam int NT = 4, NE = 4, LB = 32, LAW = 6;
    localparam int LW = LB * 8, LINES = 1 << LAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           st_valid = 0, fill_req = 0, commit_req = 0;
    logic [1:0]     st_thr = 0, fill_thr = 0, commit_thr = 0;
    logic [LAW-1:0] st_line = 0, fill_line = 0;
    logic [4:0]     st_off = 0;
    logic [7:0]     st_byte = 0;
    logic [NT-1:0]  squash = 0;
    logic           st_stall, fill_valid, commit_done;
    logic [LW-1:0]  fill_data;

    spec_store_buffers u_spec_store_buffers (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_thr(st_thr), .st_line(st_line), .st_off(st_off),
        .st_byte(st_byte), .st_stall(st_stall),
        .fill_req(fill_req), .fill_thr(fill_thr), .fill_line(fill_line),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .commit_req(commit_req), .commit_thr(commit_thr), .commit_done(commit_done),
        .squash(squash)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model built from the requirements.
    logic [LB-1:0] mv [NT][LINES];
    logic [LW-1:0] md [NT][LINES];
    logic [LW-1:0] mm [LINES];
    int head_m = 0;

    logic [LW-1:0] exp_q[$];
    string         req_q[$];

    task automatic chk(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lines_in(int t);
        int n = 0;
        for (int l = 0; l < LINES; l++) if (mv[t][l] != '0) n++;
        return n;
    endfunction

    function automatic logic [LW-1:0] model_fill(int r, int ln);
        logic [LW-1:0] v = mm[ln];
        int ar = (r - head_m + NT) % NT;
        for (int a = 0; a <= ar; a++) begin
            int t = (head_m + a) % NT;
            for (int b = 0; b < LB; b++) if (mv[t][ln][b]) v[b*8 +: 8] = md[t][ln][b*8 +: 8];
        end
        return v;
    endfunction

    task automatic do_store(int t, int ln, int off, logic [7:0] dat, string req);
        bit exp_stall;
        st_valid = 1; st_thr = 2'(t); st_line = LAW'(ln); st_off = 5'(off); st_byte = dat;
        #1;
        exp_stall = (mv[t][ln] == '0) && (lines_in(t) >= NE);
        chk(st_stall == exp_stall, req, "store stall", LW'(st_stall), LW'(exp_stall));
        if (!exp_stall) begin
            mv[t][ln][off]          = 1'b1;
            md[t][ln][off*8 +: 8]   = dat;
        end
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic do_fill(int r, int ln, string req);
        fill_req = 1; fill_thr = 2'(r); fill_line = LAW'(ln);
        exp_q.push_back(model_fill(r, ln));
        req_q.push_back(req);
        @(negedge clk);
        fill_req = 0;
    endtask

    task automatic do_commit(int t, bit accept, string req);
        int c = 0;
        int k;
        bit seen = 0;
        k = lines_in(t);
        commit_req = 1; commit_thr = 2'(t);
        @(negedge clk);
        commit_req = 0;
        if (accept) begin
            do begin
                @(negedge clk);
                c++;
            end while (!commit_done && c < 40);
            chk(c == k + 1, req, "cycles to done", LW'(c), LW'(k + 1));
            for (int l = 0; l < LINES; l++) begin
                for (int b = 0; b < LB; b++) if (mv[t][l][b]) mm[l][b*8 +: 8] = md[t][l][b*8 +: 8];
                mv[t][l] = '0;
            end
            head_m = (head_m + 1) % NT;
            @(negedge clk);
            chk(commit_done == 1'b0, req, "done width", LW'(commit_done), '0);
        end else begin
            repeat (8) begin
                @(negedge clk);
                if (commit_done) seen = 1;
            end
            chk(!seen, req, "done after ignored commit", LW'(seen), '0);
        end
    endtask

    task automatic do_squash(int t);
        squash = NT'(1) << t;
        @(negedge clk);
        squash = '0;
        for (int l = 0; l < LINES; l++) mv[t][l] = '0;
    endtask

    // Monitor: pops the scoreboard as fill results appear.
    always @(negedge clk) begin
        if (rst_n && fill_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3", "fill without request", fill_data, '0);
            end else begin
                logic [LW-1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(fill_data === e, r, "fill line", fill_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++)
            for (int l = 0; l < LINES; l++) begin mv[t][l] = '0; md[t][l] = '0; end
        for (int l = 0; l < LINES; l++) mm[l] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs and zeroed shared store
        chk(st_stall == 0 && fill_valid == 0 && commit_done == 0, "R1", "idle outputs",
            LW'({st_stall, fill_valid, commit_done}), '0);
        do_fill(0, 5, "R1");
        do_fill(3, 40, "R1");

        // R2: per-thread capture, same-line merge and overwrite
        do_store(1, 5, 0, 8'h11, "R2");
        do_store(1, 5, 31, 8'h1F, "R2");
        do_store(1, 5, 0, 8'h12, "R2");
        do_store(0, 5, 0, 8'hA0, "R2");
        do_store(0, 5, 1, 8'hA1, "R2");
        do_store(2, 5, 1, 8'hB1, "R2");
        do_store(2, 5, 2, 8'hB2, "R2");
        do_fill(1, 5, "R2");
        do_fill(1, 6, "R3");
        // R4: older requester never sees younger buffers
        do_fill(0, 5, "R4");
        // R5: youngest eligible wins per byte
        do_fill(2, 5, "R5");
        do_fill(3, 5, "R5");

        // R6: capacity stall and drop
        do_store(3, 10, 0, 8'h30, "R6");
        do_store(3, 11, 0, 8'h31, "R6");
        do_store(3, 12, 0, 8'h32, "R6");
        do_store(3, 13, 0, 8'h33, "R6");
        do_store(3, 14, 0, 8'h34, "R6");
        do_store(3, 10, 5, 8'h35, "R6");
        do_fill(3, 14, "R6");
        do_fill(3, 10, "R6");

        // R7: out-of-order commit ignored, contents kept
        do_commit(2, 0, "R7");
        do_fill(2, 5, "R7");

        // R8: oldest thread drains
        do_commit(0, 1, "R8");
        do_fill(1, 5, "R8");
        // R10: former oldest is now youngest and sees all others
        do_fill(0, 5, "R10");
        do_fill(0, 10, "R10");

        // R9: discard thread 3
        do_squash(3);
        do_fill(3, 10, "R9");
        do_fill(3, 5, "R9");

        // R8: masked writes keep unflagged bytes; empty drain takes one cycle
        do_commit(1, 1, "R8");
        do_commit(2, 1, "R8");
        do_fill(3, 5, "R8");
        do_commit(3, 1, "R8");
        // R10: ring wrapped back to thread 0 as oldest
        do_store(0, 7, 3, 8'hC3, "R10");
        do_fill(3, 7, "R10");
        do_commit(1, 0, "R10");
        do_commit(0, 1, "R10");
        do_fill(1, 7, "R10");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "pending fills", LW'(exp_q.size()), '0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule